// File: doc/BRIEF.md
# x86 Instruction Prefix Front-End Decoder

This block is the byte-serial front of an x86 instruction decoder. It takes one instruction byte per cycle over a valid/ready input, together with a flag that says whether the core is in long mode. It collects the legacy prefixes into their four groups. In long mode it also collects a REX prefix and its W, R, X and B bits. It then follows the opcode escape bytes to pick an opcode map. When it reaches the primary opcode byte, it emits one decoded record for one cycle. The record carries the prefix state, the effective segment override, the REX fields, the map, the opcode byte and the error flags.

The control is a four-state machine:

- `S_SCAN` takes prefixes and the first opcode byte.
- `S_ESC1` follows a 0x0F escape.
- `S_ESC2` follows 0x0F 0x38 or 0x0F 0x3A.
- `S_DONE` presents the record. In this state `in_ready` is low and all gathered state is cleared.

The transitions are:

- **scan_stay**: a legacy prefix, or a REX byte in long mode, keeps the machine in `S_SCAN`.
- **scan_esc**: the byte 0x0F moves it to `S_ESC1`.
- **esc1_esc2**: a 0x38 or 0x3A byte in `S_ESC1` moves it to `S_ESC2`.
- **finish**: any opcode byte, or a length overrun, moves it to `S_DONE`.
- **restart**: `S_DONE` always returns to `S_SCAN`.

The bytes that follow the opcode (ModRM and later) belong to a downstream unit.

Top module: `insn_prefix_front`

## Requirements
- R1: When the opcode byte is accepted on a rising edge, `out_valid` is high for exactly the following cycle, and `in_ready` is low during that cycle. With no prefixes and no escape, the record shows map 0 (one-byte), the opcode byte and all flags clear.
- R2: The legacy prefix bytes are classified as follows, and each sets its field:
  - 0xF0 gives `out_grp1`=1 (LOCK), 0xF2 gives 2 (REPNE) and 0xF3 gives 3 (REP).
  - The segment overrides set `out_seg`: 0x26 gives 1 (ES), 0x2E gives 2 (CS), 0x36 gives 3 (SS), 0x3E gives 4 (DS), 0x64 gives 5 (FS) and 0x65 gives 6 (GS).
  - 0x66 sets `out_opsize`.
  - 0x67 sets `out_addrsize`.
  - Prefixes may come in any order.
- R3: A second prefix from a group already seen sets `out_err_group`. The last prefix of that group wins.
- R4: The map field `out_map` is chosen by the escape bytes:
  - no escape gives 0;
  - 0x0F followed by the opcode gives 1;
  - 0x0F 0x38 gives 2;
  - 0x0F 0x3A gives 3.
  - `out_opcode` is the byte after the escape.
- R5: In long mode, a byte 0x40..0x4F seen while scanning prefixes is a REX prefix. It sets `out_rex_valid`, and `out_rex` = {W,R,X,B} = byte bits 3..0.
- R6: Outside long mode, bytes 0x40..0x4F are opcodes: map 0, and `out_rex_valid` stays 0.
- R7: A REX byte that arrives while an earlier REX is still held sets `out_err_multirex`. The last REX byte supplies the fields.
- R8: A legacy prefix that follows a REX byte discards the held REX: `out_rex_valid`=0 and `out_rex`=0.
- R9: A first byte of 0xC4 gives map 4, 0xC5 gives map 5 and 0x8F gives map 6. That byte is reported as the opcode and the record is emitted at once.
- R10: In long mode, the CS, SS, DS and ES overrides set `out_seg_ignored` and leave `out_seg` unchanged. FS and GS still take effect.
- R11: If the 15th byte of an instruction is still not the opcode, the record is emitted on that byte with `out_err_len`=1 and `out_opcode`=0. This record reflects the prefixes before that byte.
- R12: A fifth legacy prefix in one instruction sets `out_err_count`.
- R13: After reset and after every record, the decoder starts a new instruction with cleared state. The next record carries nothing from the previous instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Decoder can accept a byte |
| in_byte | input | 8 | Instruction byte |
| long_mode | input | 1 | Core is in 64-bit mode |
| out_valid | output | 1 | Decoded record valid (one cycle) |
| out_grp1 | output | 2 | 0 none, 1 LOCK, 2 REPNE, 3 REP |
| out_seg | output | 3 | Effective segment override code |
| out_seg_ignored | output | 1 | Ignored segment override seen in long mode |
| out_opsize | output | 1 | Operand-size override present |
| out_addrsize | output | 1 | Address-size override present |
| out_rex_valid | output | 1 | REX prefix in effect |
| out_rex | output | 4 | REX {W,R,X,B} |
| out_map | output | 3 | Opcode map select |
| out_opcode | output | 8 | Primary opcode byte |
| out_err_group | output | 1 | Same-group prefix conflict |
| out_err_multirex | output | 1 | More than one REX prefix |
| out_err_len | output | 1 | Length limit reached before the opcode |
| out_err_count | output | 1 | More than four legacy prefixes |

## Verification
Most internal faults in this block show up in the one record emitted right after the opcode byte.

- A wrongly latched group, segment or REX register gives a wrong field in that record, and the bench compares every field.
- A state-machine fault shows in the map value, in the opcode byte taken from the wrong position, or in `out_valid` firing on a prefix byte.
- State that leaks between instructions appears in the next record. For that reason each prefix-heavy case is followed by a plain instruction.
- A length-counter fault shows as a missing or premature `out_err_len` on the 15th byte.

// File: rtl/ipf_pkg.sv
package ipf_pkg;

    typedef enum logic [1:0] {
        S_SCAN = 2'd0,
        S_ESC1 = 2'd1,
        S_ESC2 = 2'd2,
        S_DONE = 2'd3
    } ipf_state_e;

    typedef enum logic [2:0] {
        MAP_ONE  = 3'd0,
        MAP_0F   = 3'd1,
        MAP_0F38 = 3'd2,
        MAP_0F3A = 3'd3,
        MAP_VEX3 = 3'd4,
        MAP_VEX2 = 3'd5,
        MAP_XOP  = 3'd6
    } ipf_map_e;

    localparam logic [2:0] SEG_NONE = 3'd0;
    localparam logic [2:0] SEG_ES   = 3'd1;
    localparam logic [2:0] SEG_CS   = 3'd2;
    localparam logic [2:0] SEG_SS   = 3'd3;
    localparam logic [2:0] SEG_DS   = 3'd4;
    localparam logic [2:0] SEG_FS   = 3'd5;
    localparam logic [2:0] SEG_GS   = 3'd6;

    localparam int GROUPS = 4;

    typedef struct packed {
        logic       legacy;     // any legacy prefix
        logic [1:0] grp;        // group index 0..3
        logic [1:0] g1code;     // LOCK/REPNE/REP code
        logic [2:0] segcode;    // segment code
        logic       seg_old;    // ES/CS/SS/DS
        logic       rex_shape;  // 0x40..0x4F
        logic       esc;        // 0x0F
        logic       vex;        // C4/C5/8F
        ipf_map_e   vex_map;
    } ipf_class_t;

endpackage

// File: rtl/ipf_classify.sv
module ipf_classify
    import ipf_pkg::*;
(
    input  logic [7:0] byte_i,
    output ipf_class_t cls_o
);
    always_comb begin
        cls_o = '0;
        cls_o.vex_map = MAP_ONE;
        unique case (byte_i)
            8'hF0: begin cls_o.legacy = 1'b1; cls_o.grp = 2'd0; cls_o.g1code = 2'd1; end
            8'hF2: begin cls_o.legacy = 1'b1; cls_o.grp = 2'd0; cls_o.g1code = 2'd2; end
            8'hF3: begin cls_o.legacy = 1'b1; cls_o.grp = 2'd0; cls_o.g1code = 2'd3; end
            8'h26: begin cls_o.legacy = 1'b1; cls_o.grp = 2'd1; cls_o.segcode = SEG_ES; cls_o.seg_old = 1'b1; end
            8'h2E: begin cls_o.legacy = 1'b1; cls_o.grp = 2'd1; cls_o.segcode = SEG_CS; cls_o.seg_old = 1'b1; end
            8'h36: begin cls_o.legacy = 1'b1; cls_o.grp = 2'd1; cls_o.segcode = SEG_SS; cls_o.seg_old = 1'b1; end
            8'h3E: begin cls_o.legacy = 1'b1; cls_o.grp = 2'd1; cls_o.segcode = SEG_DS; cls_o.seg_old = 1'b1; end
            8'h64: begin cls_o.legacy = 1'b1; cls_o.grp = 2'd1; cls_o.segcode = SEG_FS; end
            8'h65: begin cls_o.legacy = 1'b1; cls_o.grp = 2'd1; cls_o.segcode = SEG_GS; end
            8'h66: begin cls_o.legacy = 1'b1; cls_o.grp = 2'd2; end
            8'h67: begin cls_o.legacy = 1'b1; cls_o.grp = 2'd3; end
            8'h0F: cls_o.esc = 1'b1;
            8'hC4: begin cls_o.vex = 1'b1; cls_o.vex_map = MAP_VEX3; end
            8'hC5: begin cls_o.vex = 1'b1; cls_o.vex_map = MAP_VEX2; end
            8'h8F: begin cls_o.vex = 1'b1; cls_o.vex_map = MAP_XOP; end
            default: cls_o.rex_shape = (byte_i[7:4] == 4'b0100);
        endcase
    end
endmodule

// File: rtl/ipf_len_counter.sv
module ipf_len_counter #(
    parameter int MAX_LEN = 15,
    localparam int CW = $clog2(MAX_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic at_last_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)
            cnt_q <= '0;
        else if (step_i && cnt_q != CW'(MAX_LEN))
            cnt_q <= cnt_q + 1'b1;
    end

    assign at_last_o = (cnt_q == CW'(MAX_LEN - 1));
endmodule

// File: rtl/insn_prefix_front.sv
module insn_prefix_front
    import ipf_pkg::*;
#(
    parameter int MAX_LEN  = 15,
    parameter int MAX_PFX  = 4,
    localparam int PCW = $clog2(MAX_PFX + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_byte,
    input  logic       long_mode,
    output logic       out_valid,
    output logic [1:0] out_grp1,
    output logic [2:0] out_seg,
    output logic       out_seg_ignored,
    output logic       out_opsize,
    output logic       out_addrsize,
    output logic       out_rex_valid,
    output logic [3:0] out_rex,
    output logic [2:0] out_map,
    output logic [7:0] out_opcode,
    output logic       out_err_group,
    output logic       out_err_multirex,
    output logic       out_err_len,
    output logic       out_err_count
);
    ipf_state_e state_q, state_d;
    ipf_class_t cls;
    logic       accept, at_last, finish, len_hit, is_pfx, is_rex;
    ipf_map_e   map_q, map_fin;

    logic [1:0]       g1_q;
    logic [2:0]       seg_q;
    logic             seg_ign_q, opsz_q, adsz_q;
    logic [GROUPS-1:0] seen_q;
    logic             rexv_q, multi_q, conf_q, over_q;
    logic [3:0]       rex_q;
    logic [PCW-1:0]   npfx_q;

    ipf_classify u_cls (.byte_i(in_byte), .cls_o(cls));

    ipf_len_counter #(.MAX_LEN(MAX_LEN)) u_len (
        .clk(clk), .rst_n(rst_n),
        .clear_i(state_q == S_DONE),
        .step_i(accept),
        .at_last_o(at_last)
    );

    assign in_ready = (state_q != S_DONE);
    assign accept   = in_valid && in_ready;
    assign is_pfx   = (state_q == S_SCAN) && cls.legacy;
    assign is_rex   = (state_q == S_SCAN) && cls.rex_shape && long_mode;

    // next-state logic
    always_comb begin
        state_d = state_q;
        finish  = 1'b0;
        len_hit = 1'b0;
        map_fin = map_q;
        unique case (state_q)
            S_SCAN: begin
                if (accept) begin
                    if (cls.legacy || is_rex) begin
                        len_hit = at_last;
                    end else if (cls.esc) begin
                        state_d = S_ESC1;
                        len_hit = at_last;
                    end else begin
                        finish  = 1'b1;
                        map_fin = cls.vex ? cls.vex_map : MAP_ONE;
                    end
                end
            end
            S_ESC1: begin
                if (accept) begin
                    if (in_byte == 8'h38 || in_byte == 8'h3A) begin
                        state_d = S_ESC2;
                        len_hit = at_last;
                    end else begin
                        finish  = 1'b1;
                        map_fin = MAP_0F;
                    end
                end
            end
            S_ESC2: finish = accept;
            S_DONE: state_d = S_SCAN;
        endcase
        if (len_hit) finish = 1'b1;
        if (finish)  state_d = S_DONE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_SCAN;
        else        state_q <= state_d;
    end

    // per-instruction accumulators
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == S_DONE) begin
            g1_q <= '0; seg_q <= SEG_NONE; seg_ign_q <= 1'b0;
            opsz_q <= 1'b0; adsz_q <= 1'b0; seen_q <= '0;
            rexv_q <= 1'b0; rex_q <= '0; multi_q <= 1'b0;
            conf_q <= 1'b0; over_q <= 1'b0; npfx_q <= '0;
            map_q <= MAP_ONE;
        end else if (accept) begin
            if (is_pfx) begin
                if (seen_q[cls.grp]) conf_q <= 1'b1;
                seen_q[cls.grp] <= 1'b1;
                if (npfx_q == PCW'(MAX_PFX)) over_q <= 1'b1;
                else                          npfx_q <= npfx_q + 1'b1;
                rexv_q <= 1'b0;
                rex_q  <= '0;
                unique case (cls.grp)
                    2'd0: g1_q <= cls.g1code;
                    2'd1: begin
                        if (long_mode && cls.seg_old) seg_ign_q <= 1'b1;
                        else                          seg_q <= cls.segcode;
                    end
                    2'd2: opsz_q <= 1'b1;
                    2'd3: adsz_q <= 1'b1;
                endcase
            end else if (is_rex) begin
                if (rexv_q) multi_q <= 1'b1;
                rexv_q <= 1'b1;
                rex_q  <= in_byte[3:0];
            end else if (state_q == S_ESC1) begin
                if (in_byte == 8'h38)      map_q <= MAP_0F38;
                else if (in_byte == 8'h3A) map_q <= MAP_0F3A;
            end
        end
    end

    // output record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0; out_grp1 <= '0; out_seg <= '0;
            out_seg_ignored <= 1'b0; out_opsize <= 1'b0; out_addrsize <= 1'b0;
            out_rex_valid <= 1'b0; out_rex <= '0; out_map <= '0; out_opcode <= '0;
            out_err_group <= 1'b0; out_err_multirex <= 1'b0;
            out_err_len <= 1'b0; out_err_count <= 1'b0;
        end else begin
            out_valid <= finish;
            if (finish) begin
                out_grp1         <= g1_q;
                out_seg          <= seg_q;
                out_seg_ignored  <= seg_ign_q;
                out_opsize       <= opsz_q;
                out_addrsize     <= adsz_q;
                out_rex_valid    <= rexv_q;
                out_rex          <= rex_q;
                out_map          <= len_hit ? MAP_ONE : map_fin;
                out_opcode       <= len_hit ? 8'h00 : in_byte;
                out_err_group    <= conf_q;
                out_err_multirex <= multi_q;
                out_err_len      <= len_hit;
                out_err_count    <= over_q;
            end
        end
    end
endmodule

// File: rtl/ipf_checker.sv
module ipf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic [2:0] out_map,
    input logic [7:0] out_opcode,
    input logic       out_err_len
);
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r1_stall_on_emit: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    a_r1_emit_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid));

    a_r4_map_legal: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_map <= 3'd6);

    a_r9_vex3_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_map == 3'd4) |-> out_opcode == 8'hC4);

    a_r11_len_record: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err_len) |-> (out_map == 3'd0 && out_opcode == 8'h00));
endmodule

bind insn_prefix_front ipf_checker u_ipf_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_map(out_map), .out_opcode(out_opcode),
    .out_err_len(out_err_len)
);

// File: tb/insn_prefix_front_test.sv
module insn_prefix_front_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic long_mode = 1'b0;
    logic in_ready, out_valid, out_seg_ignored, out_opsize, out_addrsize;
    logic out_rex_valid, out_err_group, out_err_multirex, out_err_len, out_err_count;
    logic [1:0] out_grp1;
    logic [2:0] out_seg, out_map;
    logic [3:0] out_rex;
    logic [7:0] out_opcode;

    int total = 0;
    int bad = 0;
    logic [7:0] q[$];

    always #4 clk = ~clk;   // 125 MHz

    insn_prefix_front uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .long_mode(long_mode), .out_valid(out_valid),
        .out_grp1(out_grp1), .out_seg(out_seg), .out_seg_ignored(out_seg_ignored),
        .out_opsize(out_opsize), .out_addrsize(out_addrsize),
        .out_rex_valid(out_rex_valid), .out_rex(out_rex), .out_map(out_map),
        .out_opcode(out_opcode), .out_err_group(out_err_group),
        .out_err_multirex(out_err_multirex), .out_err_len(out_err_len),
        .out_err_count(out_err_count)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive the queued bytes, then sample at the negedge after the last accept
    task automatic fire();
        for (int i = 0; i < q.size(); i++) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_byte  = q[i];
            if (i != q.size() - 1) begin
                @(posedge clk);
                chk("R1 no early record", int'(out_valid), 0);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        q.delete();
    endtask

    task automatic rec(input string tag, input int g1, input int seg, input int sign,
                       input int op, input int ad, input int rv, input int rex,
                       input int map, input int opc, input int conf, input int mr,
                       input int ln, input int ov);
        chk({tag, " valid"},  int'(out_valid), 1);
        chk({tag, " grp1"},   int'(out_grp1), g1);
        chk({tag, " seg"},    int'(out_seg), seg);
        chk({tag, " segign"}, int'(out_seg_ignored), sign);
        chk({tag, " opsize"}, int'(out_opsize), op);
        chk({tag, " adsize"}, int'(out_addrsize), ad);
        chk({tag, " rexv"},   int'(out_rex_valid), rv);
        chk({tag, " rex"},    int'(out_rex), rex);
        chk({tag, " map"},    int'(out_map), map);
        chk({tag, " opcode"}, int'(out_opcode), opc);
        chk({tag, " errgrp"}, int'(out_err_group), conf);
        chk({tag, " multi"},  int'(out_err_multirex), mr);
        chk({tag, " len"},    int'(out_err_len), ln);
        chk({tag, " count"},  int'(out_err_count), ov);
    endtask

    task automatic t_plain();   // R1
        long_mode = 1'b0;
        q = '{8'h90};
        fire();
        chk("R1 ready low on emit", int'(in_ready), 0);
        rec("R1 plain", 0,0,0,0,0,0,0, 0,8'h90, 0,0,0,0);
        @(negedge clk);
        chk("R1 pulse ends", int'(out_valid), 0);
        chk("R13 ready back", int'(in_ready), 1);
    endtask

    task automatic t_groups();  // R2 R4
        long_mode = 1'b0;
        q = '{8'h66, 8'h67, 8'hF0, 8'h2E, 8'h0F, 8'hAF};
        fire();
        rec("R2 four groups", 1,2,0,1,1,0,0, 1,8'hAF, 0,0,0,0);
        q = '{8'h65, 8'hF2, 8'h0F, 8'h3A, 8'h0F};
        fire();
        rec("R4 map 0F3A", 2,6,0,0,0,0,0, 3,8'h0F, 0,0,0,0);
    endtask

    task automatic t_conflict();  // R3
        long_mode = 1'b0;
        q = '{8'hF2, 8'hF3, 8'h90};
        fire();
        rec("R3 last rep wins", 3,0,0,0,0,0,0, 0,8'h90, 1,0,0,0);
        q = '{8'h3E, 8'h36, 8'hA5};
        fire();
        rec("R3 last seg wins", 0,3,0,0,0,0,0, 0,8'hA5, 1,0,0,0);
    endtask

    task automatic t_rex();  // R5 R6 R7 R8
        long_mode = 1'b1;
        q = '{8'h48, 8'h0F, 8'h38, 8'h01};
        fire();
        rec("R5 rex W map 0F38", 0,0,0,0,0,1,4'h8, 2,8'h01, 0,0,0,0);
        q = '{8'h41, 8'h4C, 8'h90};
        fire();
        rec("R7 multi rex", 0,0,0,0,0,1,4'hC, 0,8'h90, 0,1,0,0);
        q = '{8'h48, 8'h66, 8'h90};
        fire();
        rec("R8 rex discarded", 0,0,0,1,0,0,0, 0,8'h90, 0,0,0,0);
        long_mode = 1'b0;
        q = '{8'h48};
        fire();
        rec("R6 0x48 opcode outside long", 0,0,0,0,0,0,0, 0,8'h48, 0,0,0,0);
    endtask

    task automatic t_vex();  // R9
        long_mode = 1'b1;
        q = '{8'hC4};
        fire();
        rec("R9 vex3", 0,0,0,0,0,0,0, 4,8'hC4, 0,0,0,0);
        q = '{8'h66, 8'hC5};
        fire();
        rec("R9 vex2", 0,0,0,1,0,0,0, 5,8'hC5, 0,0,0,0);
        q = '{8'h8F};
        fire();
        rec("R9 xop", 0,0,0,0,0,0,0, 6,8'h8F, 0,0,0,0);
    endtask

    task automatic t_seg64();  // R10
        long_mode = 1'b1;
        q = '{8'h64, 8'h3E, 8'h8B};
        fire();
        rec("R10 FS kept DS ignored", 0,5,1,0,0,0,0, 0,8'h8B, 1,0,0,0);
        q = '{8'h26, 8'h8B};
        fire();
        rec("R10 ES ignored", 0,0,1,0,0,0,0, 0,8'h8B, 0,0,0,0);
    endtask

    task automatic t_limits();  // R11 R12 R13
        long_mode = 1'b0;
        q = '{8'h66, 8'h67, 8'hF0, 8'h2E, 8'h26, 8'h90};
        fire();
        rec("R12 five prefixes", 1,1,0,1,1,0,0, 0,8'h90, 1,0,0,1);
        for (int i = 0; i < 15; i++) q.push_back(8'h66);
        fire();
        rec("R11 length overrun", 0,0,0,1,0,0,0, 0,8'h00, 1,0,1,1);
        q = '{8'hC3};
        fire();
        rec("R13 clean after error", 0,0,0,0,0,0,0, 0,8'hC3, 0,0,0,0);
        for (int i = 0; i < 14; i++) q.push_back(8'h67);
        q.push_back(8'h90);
        fire();
        rec("R11 opcode on byte 15", 0,0,0,0,1,0,0, 0,8'h90, 1,0,0,1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R13 reset valid", int'(out_valid), 0);
        chk("R13 reset ready", int'(in_ready), 1);
        t_plain();
        t_groups();
        t_conflict();
        t_rex();
        t_vex();
        t_seg64();
        t_limits();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule